// File: doc/BRIEF.md
# Multi-port storage command arbiter

This block lets several user ports share one storage-controller command port. Every port uses the same packet stream: a command stream (commands plus write data) toward the controller and a response stream (responses plus read data) back from it. Each stream beat carries valid, ready, sop (first beat of a packet), eop (final beat of a packet) and a data word, and moves only in a cycle where valid and ready are both 1. A single-beat packet raises sop and eop together.

While no transaction is outstanding, the arbiter picks one port whose command stream shows valid with sop, taking turns in round-robin order. From the next cycle it connects that port to the controller in both directions: command beats pass through with their sideband (write, read, identify, 48-bit sector, 16-bit sector count), and response beats go back with theirs (write, read, identify, done, error). The grant lasts across the whole exchange, which may hold several response packets, and ends only when the controller hands over the final beat of a packet whose done flag is set. Back-pressure passes straight through: the controller's command ready goes to the granted port, and the granted port's response ready goes to the controller. Both paths are combinational, with no storage. Every port that is not granted sees ready low on its command stream and valid low on its response stream. The port count ranges from 2 to 8, and the data width is a multiple of 32 bits.

Top module: `stor_port_arbiter`

## Requirements
- R1: During reset and after it, with no grant: every up_cmd_ready is 0, every up_rsp_valid is 0, dc_cmd_valid is 0 and dc_rsp_ready is 0, whatever the inputs are.
- R2: While idle, a port is a candidate when its up_cmd_valid and up_cmd_sop are both 1. The winner is the first candidate at or after the rotation pointer, searching upward by index and wrapping. The pointer is 0 after reset and becomes granted index + 1 (wrapping to 0) at each release.
- R3: At most one port is granted. Every port that is not granted has up_cmd_ready = 0 and up_rsp_valid = 0.
- R4: While a grant is held, dc_cmd_valid, sop, eop, data, wr, rd, ident, lba and cnt equal the granted port's inputs, and that port's up_cmd_ready equals dc_cmd_ready.
- R5: While a grant is held, the granted port's up_rsp_valid equals dc_rsp_valid. Its sop, eop, data, wr, rd, ident, done and err equal the controller's response fields, and dc_rsp_ready equals that port's up_rsp_ready.
- R6: The grant stays on the same port across all command beats and across response packets that end with done = 0.
- R7: A response beat with dc_rsp_eop = 1 and dc_rsp_done = 1, accepted at a clock edge, frees the grant at that edge. The next cycle is idle, and a request present in an idle cycle is granted at the following edge.
- R8: While idle, the controller's response stream is not accepted (dc_rsp_ready = 0) and no command is offered (dc_cmd_valid = 0).
- R9: A port that shows valid with sop = 0 while idle is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_cmd_valid | input | NP | Per-port command beat valid |
| up_cmd_ready | output | NP | Per-port command beat ready |
| up_cmd_sop | input | NP | Per-port first beat of command packet |
| up_cmd_eop | input | NP | Per-port final beat of command packet |
| up_cmd_wr | input | NP | Per-port write command flag |
| up_cmd_rd | input | NP | Per-port read command flag |
| up_cmd_ident | input | NP | Per-port device-identify flag |
| up_cmd_lba | input | NP*48 | Per-port sector address, port i at bits [i*48 +: 48] |
| up_cmd_cnt | input | NP*16 | Per-port sector count, port i at bits [i*16 +: 16] |
| up_cmd_data | input | NP*DW | Per-port write data, port i at bits [i*DW +: DW] |
| up_rsp_valid | output | NP | Per-port response beat valid |
| up_rsp_ready | input | NP | Per-port response beat ready |
| up_rsp_sop | output | NP | Per-port first beat of response packet |
| up_rsp_eop | output | NP | Per-port final beat of response packet |
| up_rsp_wr | output | NP | Response belongs to a write |
| up_rsp_rd | output | NP | Response belongs to a read |
| up_rsp_ident | output | NP | Response belongs to an identify |
| up_rsp_done | output | NP | Final packet of the transaction |
| up_rsp_err | output | NP | Error detected in the response |
| up_rsp_data | output | NP*DW | Per-port read data, port i at bits [i*DW +: DW] |
| dc_cmd_valid | output | 1 | Controller command beat valid |
| dc_cmd_ready | input | 1 | Controller command beat ready |
| dc_cmd_sop | output | 1 | First beat of command packet |
| dc_cmd_eop | output | 1 | Final beat of command packet |
| dc_cmd_wr | output | 1 | Write command flag |
| dc_cmd_rd | output | 1 | Read command flag |
| dc_cmd_ident | output | 1 | Identify command flag |
| dc_cmd_lba | output | 48 | Sector address |
| dc_cmd_cnt | output | 16 | Sector count |
| dc_cmd_data | output | DW | Write data |
| dc_rsp_valid | input | 1 | Controller response beat valid |
| dc_rsp_ready | output | 1 | Controller response beat ready |
| dc_rsp_sop | input | 1 | First beat of response packet |
| dc_rsp_eop | input | 1 | Final beat of response packet |
| dc_rsp_wr | input | 1 | Response to a write |
| dc_rsp_rd | input | 1 | Response to a read |
| dc_rsp_ident | input | 1 | Response to an identify |
| dc_rsp_done | input | 1 | Final packet of the transaction |
| dc_rsp_err | input | 1 | Error flag |
| dc_rsp_data | input | DW | Read data |

## Verification
Directed transactions first walk the rotation pointer through full, partial and wrapping request masks, and one case puts a valid beat without sop next to a real request to show that sop is what makes a port a candidate. Multi-packet responses whose early packets end with done low separate a grant that is truly held from one that a plain packet end would release. A spurious response beat offered right after release confirms the idle cycle. Random transactions then vary request masks, command and response lengths, and stalls on both ready paths, so that wrong steering or wrong back-pressure routing shows up as a field or ready mismatch on a specific port.

// File: rtl/stor_arb_pkg.sv
package stor_arb_pkg;
  localparam int LBA_W = 48;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             ident;
    logic [LBA_W-1:0] lba;
    logic [CNT_W-1:0] cnt;
  } cmd_side_t;

  typedef struct packed {
    logic wr;
    logic rd;
    logic ident;
    logic done;
    logic err;
  } rsp_side_t;
endpackage

// File: rtl/stor_rr_pick.sv
module stor_rr_pick #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0] req,
  input  logic [IW-1:0] ptr,
  output logic          pick_vld,
  output logic [IW-1:0] pick_idx
);
  // Scan downward so the candidate nearest the pointer is written last.
  always_comb begin
    int j;
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = NP - 1; k >= 0; k--) begin
      j = int'(ptr) + k;
      if (j >= NP) j = j - NP;
      if (req[j]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/stor_grant_ctl.sv
module stor_grant_ctl #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  input  logic          txn_end,
  output logic          busy,
  output logic [IW-1:0] gnt_idx,
  output logic [NP-1:0] gnt_vec
);
  logic [IW-1:0] ptr;
  logic          pick_vld;
  logic [IW-1:0] pick_idx;

  stor_rr_pick #(.NP(NP)) u_pick (
    .req      (req),
    .ptr      (ptr),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      gnt_idx <= '0;
      ptr     <= '0;
    end else if (!busy) begin
      if (pick_vld) begin
        busy    <= 1'b1;
        gnt_idx <= pick_idx;
      end
    end else if (txn_end) begin
      busy <= 1'b0;
      ptr  <= (gnt_idx == IW'(NP - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_vec
    assign gnt_vec[i] = busy && (gnt_idx == IW'(i));
  end

  AST_GNT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (|req)) |=> busy);                                   // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !txn_end) |=> (busy && $stable(gnt_idx)));            // R6
  AST_GNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txn_end) |=> !busy);                                  // R7
endmodule

// File: rtl/stor_cmd_mux.sv
module stor_cmd_mux
  import stor_arb_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 32,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic [IW-1:0]       gnt_idx,
  input  logic [NP-1:0]       gnt_vec,
  input  logic [NP-1:0]       up_cmd_valid,
  output logic [NP-1:0]       up_cmd_ready,
  input  logic [NP-1:0]       up_cmd_sop,
  input  logic [NP-1:0]       up_cmd_eop,
  input  logic [NP-1:0]       up_cmd_wr,
  input  logic [NP-1:0]       up_cmd_rd,
  input  logic [NP-1:0]       up_cmd_ident,
  input  logic [NP*LBA_W-1:0] up_cmd_lba,
  input  logic [NP*CNT_W-1:0] up_cmd_cnt,
  input  logic [NP*DW-1:0]    up_cmd_data,
  output logic                dc_cmd_valid,
  input  logic                dc_cmd_ready,
  output logic                dc_cmd_sop,
  output logic                dc_cmd_eop,
  output logic                dc_cmd_wr,
  output logic                dc_cmd_rd,
  output logic                dc_cmd_ident,
  output logic [LBA_W-1:0]    dc_cmd_lba,
  output logic [CNT_W-1:0]    dc_cmd_cnt,
  output logic [DW-1:0]       dc_cmd_data
);
  cmd_side_t side [NP];
  cmd_side_t sel;

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign side[i] = {up_cmd_wr[i], up_cmd_rd[i], up_cmd_ident[i],
                      up_cmd_lba[i*LBA_W +: LBA_W], up_cmd_cnt[i*CNT_W +: CNT_W]};
    assign up_cmd_ready[i] = gnt_vec[i] & dc_cmd_ready;
  end

  always_comb begin
    sel          = side[gnt_idx];
    dc_cmd_valid = busy & up_cmd_valid[gnt_idx];
    dc_cmd_sop   = up_cmd_sop[gnt_idx];
    dc_cmd_eop   = up_cmd_eop[gnt_idx];
    dc_cmd_data  = up_cmd_data[gnt_idx*DW +: DW];
  end

  assign dc_cmd_wr    = sel.wr;
  assign dc_cmd_rd    = sel.rd;
  assign dc_cmd_ident = sel.ident;
  assign dc_cmd_lba   = sel.lba;
  assign dc_cmd_cnt   = sel.cnt;

  AST_ONE_CMD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_cmd_ready));                                       // R3
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dc_cmd_valid);                                      // R8
endmodule

// File: rtl/stor_rsp_route.sv
module stor_rsp_route
  import stor_arb_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 32,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic [IW-1:0]    gnt_idx,
  input  logic [NP-1:0]    gnt_vec,
  output logic [NP-1:0]    up_rsp_valid,
  input  logic [NP-1:0]    up_rsp_ready,
  output logic [NP-1:0]    up_rsp_sop,
  output logic [NP-1:0]    up_rsp_eop,
  output logic [NP-1:0]    up_rsp_wr,
  output logic [NP-1:0]    up_rsp_rd,
  output logic [NP-1:0]    up_rsp_ident,
  output logic [NP-1:0]    up_rsp_done,
  output logic [NP-1:0]    up_rsp_err,
  output logic [NP*DW-1:0] up_rsp_data,
  input  logic             dc_rsp_valid,
  output logic             dc_rsp_ready,
  input  logic             dc_rsp_sop,
  input  logic             dc_rsp_eop,
  input  logic             dc_rsp_wr,
  input  logic             dc_rsp_rd,
  input  logic             dc_rsp_ident,
  input  logic             dc_rsp_done,
  input  logic             dc_rsp_err,
  input  logic [DW-1:0]    dc_rsp_data,
  output logic             txn_end
);
  rsp_side_t rs;
  assign rs = {dc_rsp_wr, dc_rsp_rd, dc_rsp_ident, dc_rsp_done, dc_rsp_err};

  // Payload is broadcast; only valid is steered to the owner.
  for (genvar i = 0; i < NP; i++) begin : g_port
    assign up_rsp_valid[i]          = gnt_vec[i] & dc_rsp_valid;
    assign up_rsp_sop[i]            = dc_rsp_sop;
    assign up_rsp_eop[i]            = dc_rsp_eop;
    assign up_rsp_wr[i]             = rs.wr;
    assign up_rsp_rd[i]             = rs.rd;
    assign up_rsp_ident[i]          = rs.ident;
    assign up_rsp_done[i]           = rs.done;
    assign up_rsp_err[i]            = rs.err;
    assign up_rsp_data[i*DW +: DW]  = dc_rsp_data;
  end

  assign dc_rsp_ready = busy & up_rsp_ready[gnt_idx];
  assign txn_end      = dc_rsp_valid & dc_rsp_ready & dc_rsp_eop & rs.done;

  AST_ONE_RSP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_rsp_valid));                                       // R3
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dc_rsp_ready);                                      // R8
endmodule

// File: rtl/stor_port_arbiter.sv
module stor_port_arbiter
  import stor_arb_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NP-1:0]       up_cmd_valid,
  output logic [NP-1:0]       up_cmd_ready,
  input  logic [NP-1:0]       up_cmd_sop,
  input  logic [NP-1:0]       up_cmd_eop,
  input  logic [NP-1:0]       up_cmd_wr,
  input  logic [NP-1:0]       up_cmd_rd,
  input  logic [NP-1:0]       up_cmd_ident,
  input  logic [NP*LBA_W-1:0] up_cmd_lba,
  input  logic [NP*CNT_W-1:0] up_cmd_cnt,
  input  logic [NP*DW-1:0]    up_cmd_data,
  output logic [NP-1:0]       up_rsp_valid,
  input  logic [NP-1:0]       up_rsp_ready,
  output logic [NP-1:0]       up_rsp_sop,
  output logic [NP-1:0]       up_rsp_eop,
  output logic [NP-1:0]       up_rsp_wr,
  output logic [NP-1:0]       up_rsp_rd,
  output logic [NP-1:0]       up_rsp_ident,
  output logic [NP-1:0]       up_rsp_done,
  output logic [NP-1:0]       up_rsp_err,
  output logic [NP*DW-1:0]    up_rsp_data,
  output logic                dc_cmd_valid,
  input  logic                dc_cmd_ready,
  output logic                dc_cmd_sop,
  output logic                dc_cmd_eop,
  output logic                dc_cmd_wr,
  output logic                dc_cmd_rd,
  output logic                dc_cmd_ident,
  output logic [LBA_W-1:0]    dc_cmd_lba,
  output logic [CNT_W-1:0]    dc_cmd_cnt,
  output logic [DW-1:0]       dc_cmd_data,
  input  logic                dc_rsp_valid,
  output logic                dc_rsp_ready,
  input  logic                dc_rsp_sop,
  input  logic                dc_rsp_eop,
  input  logic                dc_rsp_wr,
  input  logic                dc_rsp_rd,
  input  logic                dc_rsp_ident,
  input  logic                dc_rsp_done,
  input  logic                dc_rsp_err,
  input  logic [DW-1:0]       dc_rsp_data
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  logic          busy;
  logic [IW-1:0] gnt_idx;
  logic [NP-1:0] gnt_vec;
  logic [NP-1:0] req;
  logic          txn_end;

  assign req = up_cmd_valid & up_cmd_sop;

  stor_grant_ctl #(.NP(NP)) u_gnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .txn_end (txn_end),
    .busy    (busy),
    .gnt_idx (gnt_idx),
    .gnt_vec (gnt_vec)
  );

  stor_cmd_mux #(.NP(NP), .DW(DW)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .gnt_idx      (gnt_idx),
    .gnt_vec      (gnt_vec),
    .up_cmd_valid (up_cmd_valid),
    .up_cmd_ready (up_cmd_ready),
    .up_cmd_sop   (up_cmd_sop),
    .up_cmd_eop   (up_cmd_eop),
    .up_cmd_wr    (up_cmd_wr),
    .up_cmd_rd    (up_cmd_rd),
    .up_cmd_ident (up_cmd_ident),
    .up_cmd_lba   (up_cmd_lba),
    .up_cmd_cnt   (up_cmd_cnt),
    .up_cmd_data  (up_cmd_data),
    .dc_cmd_valid (dc_cmd_valid),
    .dc_cmd_ready (dc_cmd_ready),
    .dc_cmd_sop   (dc_cmd_sop),
    .dc_cmd_eop   (dc_cmd_eop),
    .dc_cmd_wr    (dc_cmd_wr),
    .dc_cmd_rd    (dc_cmd_rd),
    .dc_cmd_ident (dc_cmd_ident),
    .dc_cmd_lba   (dc_cmd_lba),
    .dc_cmd_cnt   (dc_cmd_cnt),
    .dc_cmd_data  (dc_cmd_data)
  );

  stor_rsp_route #(.NP(NP), .DW(DW)) u_rsp (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .gnt_idx      (gnt_idx),
    .gnt_vec      (gnt_vec),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_sop   (up_rsp_sop),
    .up_rsp_eop   (up_rsp_eop),
    .up_rsp_wr    (up_rsp_wr),
    .up_rsp_rd    (up_rsp_rd),
    .up_rsp_ident (up_rsp_ident),
    .up_rsp_done  (up_rsp_done),
    .up_rsp_err   (up_rsp_err),
    .up_rsp_data  (up_rsp_data),
    .dc_rsp_valid (dc_rsp_valid),
    .dc_rsp_ready (dc_rsp_ready),
    .dc_rsp_sop   (dc_rsp_sop),
    .dc_rsp_eop   (dc_rsp_eop),
    .dc_rsp_wr    (dc_rsp_wr),
    .dc_rsp_rd    (dc_rsp_rd),
    .dc_rsp_ident (dc_rsp_ident),
    .dc_rsp_done  (dc_rsp_done),
    .dc_rsp_err   (dc_rsp_err),
    .dc_rsp_data  (dc_rsp_data),
    .txn_end      (txn_end)
  );

  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (up_cmd_ready == '0 && up_rsp_valid == '0));         // R1
endmodule

// File: tb/stor_port_arbiter_test.sv
module stor_port_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NP-1:0]    up_cmd_valid, up_cmd_ready, up_cmd_sop, up_cmd_eop;
  logic [NP-1:0]    up_cmd_wr, up_cmd_rd, up_cmd_ident;
  logic [NP*48-1:0] up_cmd_lba;
  logic [NP*16-1:0] up_cmd_cnt;
  logic [NP*DW-1:0] up_cmd_data;
  logic [NP-1:0]    up_rsp_valid, up_rsp_ready, up_rsp_sop, up_rsp_eop;
  logic [NP-1:0]    up_rsp_wr, up_rsp_rd, up_rsp_ident, up_rsp_done, up_rsp_err;
  logic [NP*DW-1:0] up_rsp_data;
  logic             dc_cmd_valid, dc_cmd_ready, dc_cmd_sop, dc_cmd_eop;
  logic             dc_cmd_wr, dc_cmd_rd, dc_cmd_ident;
  logic [47:0]      dc_cmd_lba;
  logic [15:0]      dc_cmd_cnt;
  logic [DW-1:0]    dc_cmd_data;
  logic             dc_rsp_valid, dc_rsp_ready, dc_rsp_sop, dc_rsp_eop;
  logic             dc_rsp_wr, dc_rsp_rd, dc_rsp_ident, dc_rsp_done, dc_rsp_err;
  logic [DW-1:0]    dc_rsp_data;

  stor_port_arbiter #(.NP(NP), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .up_cmd_valid(up_cmd_valid), .up_cmd_ready(up_cmd_ready),
    .up_cmd_sop(up_cmd_sop), .up_cmd_eop(up_cmd_eop),
    .up_cmd_wr(up_cmd_wr), .up_cmd_rd(up_cmd_rd), .up_cmd_ident(up_cmd_ident),
    .up_cmd_lba(up_cmd_lba), .up_cmd_cnt(up_cmd_cnt), .up_cmd_data(up_cmd_data),
    .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
    .up_rsp_sop(up_rsp_sop), .up_rsp_eop(up_rsp_eop),
    .up_rsp_wr(up_rsp_wr), .up_rsp_rd(up_rsp_rd), .up_rsp_ident(up_rsp_ident),
    .up_rsp_done(up_rsp_done), .up_rsp_err(up_rsp_err), .up_rsp_data(up_rsp_data),
    .dc_cmd_valid(dc_cmd_valid), .dc_cmd_ready(dc_cmd_ready),
    .dc_cmd_sop(dc_cmd_sop), .dc_cmd_eop(dc_cmd_eop),
    .dc_cmd_wr(dc_cmd_wr), .dc_cmd_rd(dc_cmd_rd), .dc_cmd_ident(dc_cmd_ident),
    .dc_cmd_lba(dc_cmd_lba), .dc_cmd_cnt(dc_cmd_cnt), .dc_cmd_data(dc_cmd_data),
    .dc_rsp_valid(dc_rsp_valid), .dc_rsp_ready(dc_rsp_ready),
    .dc_rsp_sop(dc_rsp_sop), .dc_rsp_eop(dc_rsp_eop),
    .dc_rsp_wr(dc_rsp_wr), .dc_rsp_rd(dc_rsp_rd), .dc_rsp_ident(dc_rsp_ident),
    .dc_rsp_done(dc_rsp_done), .dc_rsp_err(dc_rsp_err), .dc_rsp_data(dc_rsp_data)
  );

  int total = 0;
  int bad = 0;
  int ptr_m = 0;

  logic          cw [NP];
  logic          cr [NP];
  logic          ci [NP];
  logic [47:0]   clba [NP];
  logic [15:0]   ccnt [NP];
  logic [DW-1:0] cdat [NP];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pick_exp(input int ptr, input logic [NP-1:0] mask);
    for (int k = 0; k < NP; k++) begin
      int j;
      j = (ptr + k) % NP;
      if (mask[j]) return j;
    end
    return -1;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic load_port(input int p, input bit s, input bit e);
    cw[p] = 1'($urandom); cr[p] = 1'($urandom); ci[p] = 1'($urandom);
    clba[p] = {16'($urandom), $urandom};
    ccnt[p] = 16'($urandom);
    cdat[p] = rnd_word();
    up_cmd_valid[p] = 1'b1; up_cmd_sop[p] = s; up_cmd_eop[p] = e;
    up_cmd_wr[p] = cw[p]; up_cmd_rd[p] = cr[p]; up_cmd_ident[p] = ci[p];
    up_cmd_lba[p*48 +: 48] = clba[p];
    up_cmd_cnt[p*16 +: 16] = ccnt[p];
    up_cmd_data[p*DW +: DW] = cdat[p];
  endtask

  task automatic next_beat(input int p, input bit e);
    cdat[p] = rnd_word();
    up_cmd_sop[p] = 1'b0; up_cmd_eop[p] = e;
    up_cmd_data[p*DW +: DW] = cdat[p];
  endtask

  task automatic run_txn(input logic [NP-1:0] mask, input int ncb, input int npk, input int nrb);
    int g;
    int b;
    bit taken;
    logic [NP-1:0] ev;
    @(negedge clk);
    for (int p = 0; p < NP; p++) if (mask[p]) load_port(p, 1'b1, ncb == 1);
    dc_cmd_ready = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    g = pick_exp(ptr_m, mask);
    ev = NP'(1) << g;
    chk(up_cmd_ready == ev, "R2", "grant one edge after request", 64'(up_cmd_ready), 64'(ev));
    b = 0;
    while (b < ncb) begin
      chk(dc_cmd_valid == 1'b1, "R4", "cmd valid", 64'(dc_cmd_valid), 64'd1);
      chk(dc_cmd_sop == (b == 0) && dc_cmd_eop == (b == ncb - 1), "R4", "cmd sop/eop",
          64'({dc_cmd_sop, dc_cmd_eop}), 64'({(b == 0), (b == ncb - 1)}));
      chk(dc_cmd_data == cdat[g], "R4", "cmd data", 64'(dc_cmd_data), 64'(cdat[g]));
      chk({dc_cmd_wr, dc_cmd_rd, dc_cmd_ident, dc_cmd_lba, dc_cmd_cnt} ==
          {cw[g], cr[g], ci[g], clba[g], ccnt[g]}, "R4", "cmd sideband lba",
          64'(dc_cmd_lba), 64'(clba[g]));
      chk(up_cmd_ready == (dc_cmd_ready ? ev : '0), "R3", "cmd ready only to owner",
          64'(up_cmd_ready), 64'(dc_cmd_ready ? ev : '0));
      chk(up_rsp_valid == '0, "R3", "no response before controller replies",
          64'(up_rsp_valid), 64'd0);
      taken = dc_cmd_ready;
      @(posedge clk); @(negedge clk);
      if (taken) begin
        b++;
        if (b < ncb) next_beat(g, b == ncb - 1);
        else up_cmd_valid[g] = 1'b0;
      end
      dc_cmd_ready = ($urandom % 4) != 0;
      #1;
    end
    for (int pk = 0; pk < npk; pk++) begin
      int nb;
      nb = (pk == npk - 1) ? 1 : nrb;
      for (int rb = 0; rb < nb; rb++) begin
        bit acc;
        acc = 1'b0;
        dc_rsp_valid = 1'b1;
        dc_rsp_sop = (rb == 0); dc_rsp_eop = (rb == nb - 1);
        dc_rsp_done = (pk == npk - 1);
        dc_rsp_wr = cw[g]; dc_rsp_rd = cr[g]; dc_rsp_ident = ci[g];
        dc_rsp_err = 1'($urandom);
        dc_rsp_data = rnd_word();
        while (!acc) begin
          up_rsp_ready = NP'($urandom);
          #1;
          chk(up_rsp_valid == ev, (pk > 0 && rb == 0) ? "R6" : "R5",
              "response steered to owner", 64'(up_rsp_valid), 64'(ev));
          chk(up_rsp_data[g*DW +: DW] == dc_rsp_data, "R5", "rsp data",
              64'(up_rsp_data[g*DW +: DW]), 64'(dc_rsp_data));
          chk({up_rsp_sop[g], up_rsp_eop[g], up_rsp_wr[g], up_rsp_rd[g], up_rsp_ident[g],
               up_rsp_done[g], up_rsp_err[g]} ==
              {dc_rsp_sop, dc_rsp_eop, dc_rsp_wr, dc_rsp_rd, dc_rsp_ident, dc_rsp_done, dc_rsp_err},
              "R5", "rsp fields",
              64'({up_rsp_sop[g], up_rsp_eop[g], up_rsp_done[g], up_rsp_err[g]}),
              64'({dc_rsp_sop, dc_rsp_eop, dc_rsp_done, dc_rsp_err}));
          chk(dc_rsp_ready == up_rsp_ready[g], "R5", "rsp ready from owner only",
              64'(dc_rsp_ready), 64'(up_rsp_ready[g]));
          acc = dc_rsp_ready;
          @(posedge clk); @(negedge clk);
        end
      end
    end
    // Cycle after the ending beat: grant gone, spurious beat refused.
    up_cmd_valid = '0;
    up_rsp_ready = '1;
    dc_rsp_valid = 1'b1; dc_rsp_eop = 1'b1; dc_rsp_done = 1'b1;
    #1;
    chk(dc_rsp_ready == 1'b0, "R8", "idle refuses response", 64'(dc_rsp_ready), 64'd0);
    chk(up_rsp_valid == '0, "R7", "release after done beat", 64'(up_rsp_valid), 64'd0);
    chk(up_cmd_ready == '0 && dc_cmd_valid == 1'b0, "R7", "idle after release",
        64'(up_cmd_ready), 64'd0);
    dc_rsp_valid = 1'b0;
    ptr_m = (g + 1) % NP;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    up_cmd_valid = '0; up_cmd_sop = '0; up_cmd_eop = '0;
    up_cmd_wr = '0; up_cmd_rd = '0; up_cmd_ident = '0;
    up_cmd_lba = '0; up_cmd_cnt = '0; up_cmd_data = '0; up_rsp_ready = '0;
    dc_cmd_ready = 1'b0; dc_rsp_valid = 1'b0; dc_rsp_sop = 1'b0; dc_rsp_eop = 1'b0;
    dc_rsp_wr = 1'b0; dc_rsp_rd = 1'b0; dc_rsp_ident = 1'b0; dc_rsp_done = 1'b0;
    dc_rsp_err = 1'b0; dc_rsp_data = '0;

    // R1: reset with active inputs
    @(negedge clk);
    up_cmd_valid = '1; up_cmd_sop = '1; up_rsp_ready = '1;
    dc_cmd_ready = 1'b1; dc_rsp_valid = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(up_cmd_ready == '0, "R1", "reset cmd ready", 64'(up_cmd_ready), 64'd0);
    chk(up_rsp_valid == '0, "R1", "reset rsp valid", 64'(up_rsp_valid), 64'd0);
    chk(dc_cmd_valid == 1'b0 && dc_rsp_ready == 1'b0, "R1", "reset controller side",
        64'({dc_cmd_valid, dc_rsp_ready}), 64'd0);
    up_cmd_valid = '0; up_cmd_sop = '0; dc_rsp_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    chk(up_cmd_ready == '0 && dc_cmd_valid == 1'b0, "R1", "idle after reset",
        64'(up_cmd_ready), 64'd0);

    // R9: valid without sop never wins
    up_cmd_valid[1] = 1'b1; up_cmd_sop[1] = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk); #1;
      chk(up_cmd_ready == '0 && dc_cmd_valid == 1'b0, "R9", "no grant without sop",
          64'({up_cmd_ready, dc_cmd_valid}), 64'd0);
    end
    up_cmd_valid[1] = 1'b0;

    // Directed rotation and transaction shapes
    run_txn(3'b111, 1, 1, 1);   // R2 port 0
    run_txn(3'b111, 3, 3, 2);   // R6 multi-packet, port 1
    run_txn(3'b101, 2, 2, 1);   // R2 port 2
    run_txn(3'b011, 1, 1, 4);   // R2 wrap to port 0
    @(negedge clk);
    up_cmd_valid[2] = 1'b1; up_cmd_sop[2] = 1'b0;  // R9 beside a real request
    run_txn(3'b010, 2, 2, 2);

    for (int t = 0; t < 40; t++) begin
      logic [NP-1:0] m;
      m = NP'($urandom);
      if (m == '0) m = NP'(1) << ($urandom % NP);
      run_txn(m, 1 + int'($urandom % 4), 1 + int'($urandom % 3), 1 + int'($urandom % 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule